// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block steers an external half-duplex RS-485 line transceiver on behalf of a UART transmitter. It follows two things: how many bytes wait in the transmit FIFO, and whether the transmit shift register holds a byte. While either one holds data, the block drives its direction pin high so the line driver stays enabled. When the shift register finishes the stop bit of the last byte and the FIFO is empty, a turnaround countdown starts. The countdown lasts a programmable number of bit periods. When it ends, the direction pin drops to logic 0 and the transceiver returns to receive.

The direction signal appears on one of two modem-control outputs, chosen by a select input. The output that is not selected is held at logic 0. The block also generates the transmit-empty interrupt. In the first mode the interrupt follows only the FIFO. In the second mode an empty FIFO raises the interrupt only once the shift register has finished the final stop bit.

The serializer supplies a one-cycle pulse when it loads a byte and another when it completes the last stop bit of a byte. The baud generator supplies a one-cycle pulse per bit period. Both of those units sit outside this block.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `rts_out`, `dtr_out` and `tx_empty_irq` are all 0. Reset also clears the shift-register occupancy and the turnaround state.
- R2: A `tsr_load` pulse, or a nonzero `fifo_level`, makes the selected direction pin 1 on the clock edge where it is sampled. The pin is visible one cycle later.
- R3: The direction pin never falls on an edge where neither `bit_tick` nor `tsr_done` is high. The pin also stays 1 on every edge where `fifo_level` is nonzero.
- R4: Suppose `tsr_done` is sampled while `fifo_level` is 0, no `tsr_load` is present and `turn_time` = N > 0. The pin then stays 1 through the next N-1 `bit_tick` pulses and drops on the edge of the N-th pulse. Only `bit_tick` advances the count, and idle cycles between pulses do not.
- R5: If `turn_time` is 0, the pin drops on the same edge that samples `tsr_done`. That edge is the bit tick ending the last stop bit.
- R6: If `tsr_load` or a nonzero `fifo_level` appears while the countdown runs, the countdown is abandoned and the pin stays 1. The next `tsr_done` restarts the full count.
- R7: With `dir_sel` = 0 the direction signal drives `rts_out` and `dtr_out` is 0. With `dir_sel` = 1 it drives `dtr_out` and `rts_out` is 0. Both outputs are registered.
- R8: With `irq_mode` = 0, `tx_empty_irq` is set one cycle after any edge where `fifo_level` < `tx_trigger` or `fifo_level` = 0.
- R9: With `irq_mode` = 1, `tx_empty_irq` is set one cycle after an edge where 0 < `fifo_level` < `tx_trigger`. It is also set after an edge where `fifo_level` = 0 and the shift register is empty. The shift register counts as full from a `tsr_load` until a `tsr_done`, and a load wins over a done that arrives in the same cycle.
- R10: `turn_time` is captured when the countdown starts. Changing it during a countdown does not alter that countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tsr_load | input | 1 | Pulse: a byte entered the shift register |
| tsr_done | input | 1 | Pulse: the stop bit of the shifted byte finished (coincides with a bit tick) |
| fifo_level | input | LVL_W | Bytes held in the transmit FIFO |
| tx_trigger | input | LVL_W | Transmit FIFO trigger level |
| turn_time | input | TURN_W | Turnaround delay in bit periods |
| dir_sel | input | 1 | 0: direction on rts_out, 1: direction on dtr_out |
| irq_mode | input | 1 | 0: FIFO-only empty interrupt, 1: also wait for the stop bit |
| rts_out | output | 1 | Direction pin when dir_sel = 0 (1 = drive) |
| dtr_out | output | 1 | Direction pin when dir_sel = 1 (1 = drive) |
| tx_empty_irq | output | 1 | Transmit-empty interrupt |

## Verification
The assertions check on every cycle the following properties. A load or a nonzero FIFO level forces the driver on. The pin never drops without a tick or a done pulse. The unselected output stays low. An empty FIFO in mode 0, and a fresh load in mode 1, set or clear the interrupt on the following cycle. Some behaviour depends on counting and only the bench scenarios can show it. This includes the exact tick on which the release happens for each turnaround value, and the fact that idle cycles do not count. It also includes restarting after a cancel, latching of the delay value, and the complete interrupt truth table over level, trigger, mode and occupancy.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_DRIVE = 2'd1,
    DIR_TURN  = 2'd2
  } dir_state_t;
endpackage

// File: rtl/rs485_tsr_track.sv
// Tracks whether the transmit shift register holds a byte.
module rs485_tsr_track (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic done,
  output logic occ_next
);
  logic occ_q;

  // a load in the same cycle as a done means a new byte is in place
  assign occ_next = load | (occ_q & ~done);

  always_ff @(posedge clk) begin
    if (rst) occ_q <= 1'b0;
    else     occ_q <= occ_next;
  end
endmodule

// File: rtl/rs485_turn_cnt.sv
// Turnaround down-counter in bit periods.
module rs485_turn_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_val,
  input  logic         dec,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign last = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (start)               cnt_q <= start_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/rs485_txe_irq.sv
// Transmit-empty interrupt generation in two modes.
module rs485_txe_irq #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trigger,
  input  logic             tsr_occ,
  output logic             irq
);
  logic fifo_empty;
  logic below_trig;
  logic irq_nx;

  assign fifo_empty = (level == '0);
  assign below_trig = (level < trigger);

  always_comb begin
    if (mode) irq_nx = (below_trig & ~fifo_empty) | (fifo_empty & ~tsr_occ);
    else      irq_nx = below_trig | fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_nx;
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int LVL_W  = 8,
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tsr_load,
  input  logic              tsr_done,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [LVL_W-1:0]  tx_trigger,
  input  logic [TURN_W-1:0] turn_time,
  input  logic              dir_sel,
  input  logic              irq_mode,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              tx_empty_irq
);
  import rs485_dir_pkg::*;

  dir_state_t state_q, state_nx;
  logic       fifo_nz;
  logic       busy_req;
  logic       occ_next;
  logic       cnt_start;
  logic       cnt_dec;
  logic       cnt_last;
  logic       drive_nx;

  assign fifo_nz  = (fifo_level != '0);
  assign busy_req = tsr_load | fifo_nz;

  rs485_tsr_track u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (tsr_load),
    .done     (tsr_done),
    .occ_next (occ_next)
  );

  always_comb begin
    state_nx  = state_q;
    cnt_start = 1'b0;
    cnt_dec   = 1'b0;
    case (state_q)
      DIR_IDLE: begin
        if (busy_req) state_nx = DIR_DRIVE;
      end
      DIR_DRIVE: begin
        if (tsr_done && !busy_req) begin
          if (turn_time == '0) begin
            state_nx = DIR_IDLE;
          end else begin
            state_nx  = DIR_TURN;
            cnt_start = 1'b1;
          end
        end
      end
      DIR_TURN: begin
        if (busy_req) begin
          state_nx = DIR_DRIVE;
        end else if (bit_tick) begin
          cnt_dec = 1'b1;
          if (cnt_last) state_nx = DIR_IDLE;
        end
      end
      default: state_nx = DIR_IDLE;
    endcase
  end

  rs485_turn_cnt #(.W(TURN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (cnt_start),
    .start_val (turn_time),
    .dec       (cnt_dec),
    .last      (cnt_last)
  );

  assign drive_nx = (state_nx != DIR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DIR_IDLE;
      rts_out <= 1'b0;
      dtr_out <= 1'b0;
    end else begin
      state_q <= state_nx;
      rts_out <= drive_nx & ~dir_sel;
      dtr_out <= drive_nx &  dir_sel;
    end
  end

  rs485_txe_irq #(.LVL_W(LVL_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .mode    (irq_mode),
    .level   (fifo_level),
    .trigger (tx_trigger),
    .tsr_occ (occ_next),
    .irq     (tx_empty_irq)
  );
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             tsr_load,
  input logic             tsr_done,
  input logic [LVL_W-1:0] fifo_level,
  input logic             dir_sel,
  input logic             irq_mode,
  input logic             rts_out,
  input logic             dtr_out,
  input logic             tx_empty_irq
);
  logic pin;
  assign pin = rts_out | dtr_out;

  // R1: outputs clear after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rts_out && !dtr_out && !tx_empty_irq));

  // R2
  a_r2_load_drives: assert property (@(posedge clk) disable iff (rst)
    tsr_load |=> pin);

  // R3
  a_r3_fifo_holds: assert property (@(posedge clk) disable iff (rst)
    (fifo_level != '0) |=> pin);

  a_r3_no_spurious_drop: assert property (@(posedge clk) disable iff (rst)
    (pin && !bit_tick && !tsr_done) |=> pin);

  // R7
  a_r7_rts_only: assert property (@(posedge clk) disable iff (rst)
    !dir_sel |=> !dtr_out);

  a_r7_dtr_only: assert property (@(posedge clk) disable iff (rst)
    dir_sel |=> !rts_out);

  // R8
  a_r8_mode0_empty: assert property (@(posedge clk) disable iff (rst)
    (!irq_mode && fifo_level == '0) |=> tx_empty_irq);

  // R9
  a_r9_mode1_waits: assert property (@(posedge clk) disable iff (rst)
    (irq_mode && fifo_level == '0 && tsr_load) |=> !tx_empty_irq);
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_tick     (bit_tick),
  .tsr_load     (tsr_load),
  .tsr_done     (tsr_done),
  .fifo_level   (fifo_level),
  .dir_sel      (dir_sel),
  .irq_mode     (irq_mode),
  .rts_out      (rts_out),
  .dtr_out      (dtr_out),
  .tx_empty_irq (tx_empty_irq)
);

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;
  localparam int LVL_W  = 8;
  localparam int TURN_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              bit_tick;
  logic              tsr_load;
  logic              tsr_done;
  logic [LVL_W-1:0]  fifo_level;
  logic [LVL_W-1:0]  tx_trigger;
  logic [TURN_W-1:0] turn_time;
  logic              dir_sel;
  logic              irq_mode;
  logic              rts_out;
  logic              dtr_out;
  logic              tx_empty_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rs485_dir_ctrl #(.LVL_W(LVL_W), .TURN_W(TURN_W)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tsr_load(tsr_load),
    .tsr_done(tsr_done), .fifo_level(fifo_level), .tx_trigger(tx_trigger),
    .turn_time(turn_time), .dir_sel(dir_sel), .irq_mode(irq_mode),
    .rts_out(rts_out), .dtr_out(dtr_out), .tx_empty_irq(tx_empty_irq)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sel_pin();
    return dir_sel ? int'(dtr_out) : int'(rts_out);
  endfunction

  function automatic int other_pin();
    return dir_sel ? int'(rts_out) : int'(dtr_out);
  endfunction

  task automatic pulse_load();
    tsr_load = 1; cyc(); tsr_load = 0;
  endtask

  task automatic pulse_tick();
    bit_tick = 1; cyc(); bit_tick = 0;
  endtask

  task automatic pulse_done();
    tsr_done = 1; bit_tick = 1; cyc(); tsr_done = 0; bit_tick = 0;
  endtask

  // full transmission and turnaround for a given delay
  task automatic run_turn(int t, bit sel);
    turn_time = TURN_W'(t); dir_sel = sel; fifo_level = 0;
    pulse_load();
    chk("R2 load drives pin", sel_pin(), 1);
    chk("R7 unselected pin low", other_pin(), 0);
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R3 pin held while shifting", sel_pin(), 1);
    end
    pulse_done();
    if (t == 0) chk("R5 zero delay release", sel_pin(), 0);
    else        chk("R4 held after done", sel_pin(), 1);
    for (int k = 1; k <= t; k++) begin
      cyc(); cyc();
      chk("R4 idle cycles do not count", sel_pin(), 1);
      pulse_tick();
      chk("R4 countdown release", sel_pin(), (k < t) ? 1 : 0);
    end
    chk("R7 unselected pin low", other_pin(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; bit_tick = 0; tsr_load = 0; tsr_done = 0;
    fifo_level = 0; tx_trigger = 4; turn_time = 0; dir_sel = 0; irq_mode = 0;
    cyc(); cyc();
    chk("R1 rts reset", int'(rts_out), 0);
    chk("R1 dtr reset", int'(dtr_out), 0);
    chk("R1 irq reset", int'(tx_empty_irq), 0);
    rst = 0;

    // turnaround sweep over delay and pin selection
    for (int s = 0; s < 2; s++)
      for (int t = 0; t <= 5; t++)
        run_turn(t, s[0]);
    run_turn(255, 1'b0);

    // R2: nonzero FIFO level alone enables driver
    dir_sel = 1; fifo_level = 3; cyc();
    chk("R2 fifo drives pin", sel_pin(), 1);
    pulse_done();
    chk("R3 done with fifo nonempty keeps pin", sel_pin(), 1);
    fifo_level = 0; pulse_load(); turn_time = 2;
    pulse_done(); pulse_tick(); pulse_tick();
    chk("R4 release after fifo run", sel_pin(), 0);

    // R6: cancel by a new load
    dir_sel = 0; turn_time = 4;
    pulse_load(); pulse_done(); pulse_tick(); pulse_tick();
    pulse_load();
    chk("R6 load cancels", sel_pin(), 1);
    for (int i = 0; i < 5; i++) begin
      pulse_tick();
      chk("R6 held after cancel", sel_pin(), 1);
    end
    pulse_done();
    for (int k = 1; k <= 4; k++) begin
      pulse_tick();
      chk("R6 full restart", sel_pin(), (k < 4) ? 1 : 0);
    end

    // R6: cancel by FIFO becoming nonempty
    pulse_load(); pulse_done(); pulse_tick();
    fifo_level = 2; cyc();
    chk("R6 fifo cancels", sel_pin(), 1);
    for (int i = 0; i < 6; i++) begin
      pulse_tick();
      chk("R6 held with fifo", sel_pin(), 1);
    end
    fifo_level = 0; pulse_load(); pulse_done();
    for (int k = 1; k <= 4; k++) begin
      pulse_tick();
      chk("R6 restart after fifo", sel_pin(), (k < 4) ? 1 : 0);
    end

    // R10: delay latched at start
    turn_time = 3; pulse_load(); pulse_done();
    turn_time = 1;
    for (int k = 1; k <= 3; k++) begin
      pulse_tick();
      chk("R10 latched delay", sel_pin(), (k < 3) ? 1 : 0);
    end

    // R8 / R9: interrupt truth table
    for (int m = 0; m < 2; m++)
      for (int occ = 0; occ < 2; occ++)
        for (int trg = 0; trg <= 5; trg += 5)
          for (int lvl = 0; lvl <= 7; lvl++) begin
            int exp;
            irq_mode = m[0]; tx_trigger = LVL_W'(trg); fifo_level = 0;
            if (occ == 1) pulse_load(); else pulse_done();
            fifo_level = LVL_W'(lvl); cyc();
            if (m == 0) exp = (lvl < trg || lvl == 0) ? 1 : 0;
            else        exp = ((lvl < trg && lvl != 0) || (lvl == 0 && occ == 0)) ? 1 : 0;
            chk(m == 0 ? "R8 mode0 irq" : "R9 mode1 irq", int'(tx_empty_irq), exp);
          end

    // R9: load and done edges with an empty FIFO
    irq_mode = 1; fifo_level = 0; tx_trigger = 4;
    pulse_done(); chk("R9 idle empty irq", int'(tx_empty_irq), 1);
    pulse_load(); chk("R9 load clears irq", int'(tx_empty_irq), 0);
    cyc();        chk("R9 waits for stop bit", int'(tx_empty_irq), 0);
    pulse_done(); chk("R9 stop bit sets irq", int'(tx_empty_irq), 1);
    tsr_load = 1; tsr_done = 1; cyc(); tsr_load = 0; tsr_done = 0;
    chk("R9 load wins over done", int'(tx_empty_irq), 0);

    // R1: reset mid-transmission
    pulse_load(); rst = 1; cyc();
    chk("R1 reset clears pin", sel_pin(), 0);
    rst = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule